// File: doc/BRIEF.md
# Low-Power Reseeded Test Pattern Generator

This block generates stimulus vectors for built-in self-test with little toggling between consecutive vectors. An m-bit binary counter sweeps its whole range. Each counter value is turned into its Gray code. The Gray code is combined bit by bit through XOR with a seed held in a linear feedback shift register. As a result, two neighbouring vectors inside one sweep differ in a single bit, which keeps switching in the scan path and in the logic under test low.

The seed register moves to its next state only once per sweep. It does so on the enabled clock edge where a NOR across all counter bits reports that the counter reads zero. A register update happens only on that edge, through a synchronous enable; the clock itself is never gated. Each sweep of 2^m vectors therefore uses one seed, and the next sweep uses the following state of the shift register. The output vector is registered. A valid flag marks the edges on which a new vector was produced. When the enable input is low, the counter, the seed and the output all hold their values.

Top module: `lowpower_pattern_gen`

## Requirements
- R1: While `rst` is high and on the first sample after it, `pattern_o` is all zeros, `valid_o` is 0, the counter is 0 and the seed register holds the parameter `SEED`.
- R2: The counter starts at 0 after reset. It increments by one on each enabled edge and wraps from 2^m-1 back to 0, so a sweep is exactly 2^m vectors long.
- R3: The Gray code of counter value b is b XOR (b >> 1). Within a sweep, the k-th vector XOR the sweep's seed equals k XOR (k >> 1).
- R4: The seed steps only on an enabled edge where the counter reads 0. The step shifts the seed left by one, with the new LSB set to the XOR of the seed bits selected by `TAPS`. Sweep number n (n = 1 for the first sweep after reset) uses the seed n steps beyond `SEED`.
- R5: On an enabled edge, `pattern_o` takes the XOR of the Gray code of the pre-edge counter value and the seed in effect for that counter value. The new value is visible after that edge.
- R6: Two consecutive vectors within one sweep (counter not at 0) differ in exactly one bit.
- R7: The seed register never holds all zeros, so the first vector of each sweep, which equals the seed, is nonzero.
- R8: After an edge with `en` low, `pattern_o`, the counter and the seed keep their previous values.
- R9: `valid_o` is 1 after each edge where `en` was 1 and 0 after each edge where `en` was 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock shared by the counter, the seed register and the output stage |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Advance enable; when low, all state holds |
| pattern_o | output | WIDTH | Registered test vector |
| valid_o | output | 1 | High when the last edge produced a new vector |

## Verification
The hardest case to reach is a pause in which `en` drops exactly on the edge where the counter reads zero. At that point the seed is about to step, and a wrong enable gate would let it step twice or skip a step. The bench follows its own model of the counter position. It uses that model to hold `en` low for several cycles right at sweep boundaries, and it also inserts pauses at scattered points inside sweeps. Every sweep start is then compared against the model's seed sequence.

// File: rtl/lp_tpg_pkg.sv
package lp_tpg_pkg;

    localparam int unsigned TPG_MAXW = 32;
    localparam int unsigned TPG_W_DEF = 8;

    // control word handed from the top to the output stage
    typedef struct packed {
        logic step;        // enabled edge: produce a new vector
        logic sweep_start; // counter reads zero on this edge
        logic seed_adv;    // seed register steps on this edge
    } tpg_ctl_t;

    typedef enum logic [1:0] {
        PH_HOLD  = 2'd0,
        PH_START = 2'd1,
        PH_SWEEP = 2'd2
    } tpg_phase_e;

    function automatic logic [TPG_MAXW-1:0] bin_to_gray(input logic [TPG_MAXW-1:0] b);
        return b ^ (b >> 1);
    endfunction

    function automatic tpg_phase_e phase_of(input tpg_ctl_t c);
        if (!c.step) return PH_HOLD;
        if (c.sweep_start) return PH_START;
        return PH_SWEEP;
    endfunction

endpackage

// File: rtl/tpg_bin_counter.sv
module tpg_bin_counter #(
    parameter int unsigned W = lp_tpg_pkg::TPG_W_DEF
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         step_i,
    output logic [W-1:0] cnt_o,
    output logic         zero_o
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else if (step_i) cnt_q <= cnt_q + 1'b1;
    end

    assign cnt_o  = cnt_q;
    assign zero_o = ~|cnt_q;

    // R2
    cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
        step_i |=> cnt_q == W'($past(cnt_q) + 1'b1));
    // R8
    cnt_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !step_i |=> $stable(cnt_q));
endmodule

// File: rtl/tpg_seed_lfsr.sv
module tpg_seed_lfsr #(
    parameter int unsigned   W    = lp_tpg_pkg::TPG_W_DEF,
    parameter logic [W-1:0]  TAPS = W'(8'hB8),
    parameter logic [W-1:0]  SEED = W'(8'h01)
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         adv_i,
    output logic [W-1:0] seed_o,
    output logic [W-1:0] seed_next_o
);
    logic [W-1:0] seed_q;
    logic [W-1:0] tapped;
    logic [W:0]   par_chain;
    logic         fb;

    assign tapped = seed_q & TAPS;
    assign par_chain[0] = 1'b0;

    generate
        for (genvar i = 0; i < W; i++) begin : g_par
            assign par_chain[i+1] = par_chain[i] ^ tapped[i];
        end
    endgenerate

    assign fb          = par_chain[W];
    assign seed_next_o = adv_i ? {seed_q[W-2:0], fb} : seed_q;

    always_ff @(posedge clk) begin
        if (rst) seed_q <= SEED;
        else seed_q <= seed_next_o;
    end

    assign seed_o = seed_q;

    // R7
    seed_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
        seed_q != '0);
    // R4
    seed_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !adv_i |=> $stable(seed_q));
    // R4
    seed_shift_chk: assert property (@(posedge clk) disable iff (rst)
        adv_i |=> seed_q[W-1:1] == $past(seed_q[W-2:0]));
endmodule

// File: rtl/tpg_xor_stage.sv
module tpg_xor_stage #(
    parameter int unsigned W = lp_tpg_pkg::TPG_W_DEF
) (
    input  logic                  clk,
    input  logic                  rst,
    input  lp_tpg_pkg::tpg_ctl_t  ctl_i,
    input  logic [W-1:0]          cnt_i,
    input  logic [W-1:0]          seed_i,
    output logic [W-1:0]          pat_o,
    output logic                  valid_o
);
    import lp_tpg_pkg::*;

    logic [TPG_MAXW-1:0] gray_wide;
    logic [W-1:0]        gray;
    logic [W-1:0]        pat_q;
    logic                valid_q;
    tpg_phase_e          phase;

    assign gray_wide = bin_to_gray(TPG_MAXW'(cnt_i));
    assign gray      = gray_wide[W-1:0];
    assign phase     = phase_of(ctl_i);

    always_ff @(posedge clk) begin
        if (rst) begin
            pat_q   <= '0;
            valid_q <= 1'b0;
        end else begin
            valid_q <= (phase != PH_HOLD);
            if (phase != PH_HOLD) pat_q <= seed_i ^ gray;
        end
    end

    assign pat_o   = pat_q;
    assign valid_o = valid_q;

    // R6
    one_bit_step_chk: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_SWEEP) |=> $countones(pat_q ^ $past(pat_q)) == 1);
    // R8
    pat_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_HOLD) |=> $stable(pat_q));
endmodule

// File: rtl/lowpower_pattern_gen.sv
module lowpower_pattern_gen #(
    parameter int unsigned  WIDTH = lp_tpg_pkg::TPG_W_DEF,
    parameter logic [WIDTH-1:0] TAPS = WIDTH'(8'hB8),
    parameter logic [WIDTH-1:0] SEED = WIDTH'(8'h01)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    output logic [WIDTH-1:0] pattern_o,
    output logic             valid_o
);
    import lp_tpg_pkg::*;

    logic [WIDTH-1:0] cnt;
    logic             cnt_zero;
    logic [WIDTH-1:0] seed_now;
    logic [WIDTH-1:0] seed_eff;
    tpg_ctl_t         ctl;

    assign ctl.step        = en;
    assign ctl.sweep_start = cnt_zero;
    assign ctl.seed_adv    = en & cnt_zero;

    tpg_bin_counter #(.W(WIDTH)) i_cnt (
        .clk    (clk),
        .rst    (rst),
        .step_i (ctl.step),
        .cnt_o  (cnt),
        .zero_o (cnt_zero)
    );

    tpg_seed_lfsr #(.W(WIDTH), .TAPS(TAPS), .SEED(SEED)) i_lfsr (
        .clk         (clk),
        .rst         (rst),
        .adv_i       (ctl.seed_adv),
        .seed_o      (seed_now),
        .seed_next_o (seed_eff)
    );

    tpg_xor_stage #(.W(WIDTH)) i_mix (
        .clk     (clk),
        .rst     (rst),
        .ctl_i   (ctl),
        .cnt_i   (cnt),
        .seed_i  (seed_eff),
        .pat_o   (pattern_o),
        .valid_o (valid_o)
    );

    // R9
    valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
        en |=> valid_o);
    // R9
    valid_drop_chk: assert property (@(posedge clk) disable iff (rst)
        !en |=> !valid_o);
    // R7
    sweep_first_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
        (en && cnt_zero) |=> pattern_o == seed_now);
endmodule

// File: tb/test_lowpower_pattern_gen.sv
module test_lowpower_pattern_gen;
    localparam int W    = 8;
    localparam int SPAN = 1 << W;
    localparam int MASK = SPAN - 1;
    localparam int TAPV = 'hB8;
    localparam int SEEDV = 'h01;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         en  = 1'b0;
    logic [W-1:0] pattern_o;
    logic         valid_o;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    // model state
    int m_cnt  = 0;
    int m_seed = SEEDV;
    int m_pat  = 0;
    int m_val  = 0;
    int m_steps = 0;      // seed steps since reset
    int m_last_cnt = -1;  // counter value used by the last produced vector
    int prev_pat = 0;
    int m_held = 0;

    always #2 clk = ~clk;

    lowpower_pattern_gen #(.WIDTH(W)) i_lowpower_pattern_gen (
        .clk(clk), .rst(rst), .en(en), .pattern_o(pattern_o), .valid_o(valid_o)
    );

    function automatic int next_seed(input int s);
        int p = 0;
        for (int i = 0; i < W; i++) if (((s & TAPV) >> i) & 1) p ^= 1;
        return ((s << 1) | p) & MASK;
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // compare ports with the model, then apply en and advance the model one edge
    task automatic tick(input logic e);
        @(negedge clk);
        chk("R5 pattern", int'(pattern_o), m_pat);
        chk("R9 valid", int'(valid_o), m_val);
        if (m_held) chk("R8 hold", int'(pattern_o), prev_pat);
        if (m_val && m_last_cnt == 0) begin
            chk("R4 sweep seed", int'(pattern_o), m_seed);
            chk("R7 nonzero", int'(pattern_o != 0), 1);
        end
        if (m_val && m_last_cnt > 0) begin
            chk("R6 one bit", $countones(pattern_o ^ W'(prev_pat)), 1);
            chk("R3 gray", int'(pattern_o) ^ m_seed, m_last_cnt ^ (m_last_cnt >> 1));
        end
        prev_pat = int'(pattern_o);
        en = e;
        if (e) begin
            if (m_cnt == 0) begin
                m_seed = next_seed(m_seed);
                m_steps++;
            end
            m_pat = m_seed ^ (m_cnt ^ (m_cnt >> 1));
            m_last_cnt = m_cnt;
            m_cnt = (m_cnt + 1) & MASK;
            m_val = 1;
            m_held = 0;
        end else begin
            m_val = 0;
            m_held = 1;
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 200000) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual %0d expected below 200000 cycles", cycles);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 pattern in reset", int'(pattern_o), 0);
        chk("R1 valid in reset", int'(valid_o), 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 pattern after reset", int'(pattern_o), 0);
        chk("R1 valid after reset", int'(valid_o), 0);
        // free run across several sweeps, R2 wrap exercised
        for (int i = 0; i < 3 * SPAN; i++) tick(1'b1);
        chk("R2 counter wrapped to sweep start", m_last_cnt, SPAN - 1);
        // scattered pauses inside sweeps
        for (int i = 0; i < 2 * SPAN; i++) tick((i % 7) != 3);
        // pause exactly at sweep boundaries
        for (int k = 0; k < 3; k++) begin
            while (m_cnt != 0) tick(1'b1);
            for (int j = 0; j < 5; j++) tick(1'b0);
            tick(1'b1);
            tick(1'b1);
        end
        for (int i = 0; i < SPAN; i++) tick(1'b1);
        tick(1'b0);
        chk("R4 seed step count", int'(m_steps >= 7), 1);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule